// File: doc/BRIEF.md
# Scatter-Gather Storage DMA Engine

This block moves data between a sector-based storage device and system memory without processor help. Software builds a table of region descriptors in memory, writes the table's address, picks a direction and sets a start bit. The engine then reads each descriptor in turn and moves one 32-bit word per handshake between the device port and the memory port until the device finishes or the table runs out.

The engine reports the result through three status bits: active, error and interrupt. Their combination tells software which of four outcomes occurred. A transfer may still be running. It may have completed with the table used up exactly. It may have completed with table space left over. Or it may have failed, either because of a memory fault or because the table described less data than the device moved. A memory fault halts the engine without raising the interrupt. Software can abort a stuck transfer at any time by clearing the start bit.

The memory port serves both descriptor fetches and data beats. It holds `mem_req` and `mem_addr` steady until the memory answers with `mem_ack` or `mem_err`. On the device side, the device holds `dev_req` and its data until `dev_ack`. Each `dev_ack` marks the completion of exactly one memory beat.

Top module: `sgdma_engine`

## Requirements
- R1: After reset every register reads 0 and neither `mem_req` nor `dev_ack` is asserted. Register map: address 0 is the command register (bit 0 start, bit 3 direction), address 1 is the status register (bit 0 active, bit 1 error, bit 2 interrupt), and address 2 is the table pointer (bits 1:0 read 0).
- R2: Writing start=1 while start is 0 loads the table pointer into the fetch pointer and sets active. The first memory read goes to the pointer and the second goes to the pointer plus 4.
- R3: A descriptor is two 32-bit words. The first is the region base, with bit 0 forced to 0. The second holds a byte count in bits 15:0, where 0 stands for 65536 bytes, and an end-of-table flag in bit 31. The next descriptor is read 8 bytes further on, unless the flag was set.
- R4: Direction 1 issues memory writes carrying device data. Direction 0 issues memory reads whose data goes to the device. A write to the direction bit is ignored while start is 1.
- R5: While data is moving and the device has not interrupted, status shows active=1 and interrupt=0.
- R6: When the table is used up and the device then interrupts, status shows interrupt=1 and active=0.
- R7: When the device interrupts before the table ends, status shows interrupt=1 and active=1.
- R8: When the table is used up while the device still requests data, active drops to 0, `dev_ack` is withheld, and error and interrupt stay 0.
- R9: A memory error stops the engine within one cycle, clears active, and sets error. No later device interrupt sets the interrupt bit while error is set.
- R10: Writing start=0 stops the engine, clears active, and ends memory requests in the next cycle.
- R11: Writing 1 to error or interrupt clears that bit, and writing 0 leaves it unchanged. Active ignores software writes.
- R12: A device transfer ending on a sector boundary that falls inside a region completes correctly, with addresses continuing across descriptor boundaries.
- R13: `dev_ack` is high only in a cycle where the memory acknowledges a data beat. `mem_wdata` carries `dev_wdata`, and `dev_rdata` carries `mem_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory request, held until answered |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory request completed |
| mem_err | input | 1 | Memory request failed |
| dev_req | input | 1 | Device requests a word transfer |
| dev_ack | output | 1 | Word transfer done this cycle |
| dev_wdata | input | 32 | Word from device |
| dev_rdata | output | 32 | Word to device |
| dev_irq | input | 1 | Device completion interrupt |

## Verification
The hardest situation to reach is the underflow outcome, where the table ends while the device still has data. Only the absence of an acknowledge and a quiet status reveal it. The bench gives the device a full 512-byte sector against a table holding half of that. It counts the acknowledges it receives, then keeps the request raised for a further stretch to confirm that none arrives. The memory-fault path is reached by arming the memory model to answer one mid-transfer beat with an error. The bench then raises a device interrupt to confirm that no interrupt is recorded. A sector that ends inside a region is built from descriptor sizes that are not multiples of 512.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_DESC_LO = 2'd1,
    SEQ_DESC_HI = 2'd2,
    SEQ_MOVE    = 2'd3
  } seq_state_e;

  localparam logic [1:0] RA_CMD  = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_TBL  = 2'd2;

  localparam int CMD_START_BIT = 0;
  localparam int CMD_DIR_BIT   = 3;
  localparam int ST_ACT_BIT    = 0;
  localparam int ST_ERR_BIT    = 1;
  localparam int ST_IRQ_BIT    = 2;
  localparam int DESC_EOT_BIT  = 31;
endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
  import sgdma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              active,
  input  logic              err_set,
  input  logic              dev_irq,
  output logic              start,
  output logic              dir,
  output logic [ADDR_W-1:0] tbl_ptr,
  output logic              go,
  output logic              stop,
  output logic              err_st,
  output logic              irq_st
);
  logic              start_q, start_d, dir_q, dir_d, err_q, err_d, irq_q, irq_d;
  logic              irq_in_q;
  logic [ADDR_W-1:0] tbl_q, tbl_d;
  logic              cmd_wr, stat_wr, tbl_wr, irq_rise;

  always_comb begin
    cmd_wr   = reg_wr && (reg_addr == RA_CMD);
    stat_wr  = reg_wr && (reg_addr == RA_STAT);
    tbl_wr   = reg_wr && (reg_addr == RA_TBL);
    irq_rise = dev_irq && !irq_in_q;
    go       = cmd_wr && reg_wdata[CMD_START_BIT] && !start_q;
    stop     = cmd_wr && !reg_wdata[CMD_START_BIT] && start_q;

    start_d = start_q;
    dir_d   = dir_q;
    tbl_d   = tbl_q;
    err_d   = err_q;
    irq_d   = irq_q;
    if (cmd_wr) begin
      start_d = reg_wdata[CMD_START_BIT];
      if (!start_q) dir_d = reg_wdata[CMD_DIR_BIT];
    end
    if (tbl_wr) tbl_d = {reg_wdata[ADDR_W-1:2], 2'b00};
    if (stat_wr && reg_wdata[ST_ERR_BIT]) err_d = 1'b0;
    if (err_set) err_d = 1'b1;
    if (stat_wr && reg_wdata[ST_IRQ_BIT]) irq_d = 1'b0;
    if (irq_rise && start_q && !err_q && !err_set) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= 1'b0;
      dir_q    <= 1'b0;
      tbl_q    <= '0;
      err_q    <= 1'b0;
      irq_q    <= 1'b0;
      irq_in_q <= 1'b0;
    end else begin
      if (cmd_wr) start_q <= start_d;
      if (cmd_wr) dir_q   <= dir_d;
      if (tbl_wr) tbl_q   <= tbl_d;
      err_q    <= err_d;
      irq_q    <= irq_d;
      irq_in_q <= dev_irq;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CMD: begin
        reg_rdata[CMD_START_BIT] = start_q;
        reg_rdata[CMD_DIR_BIT]   = dir_q;
      end
      RA_STAT: begin
        reg_rdata[ST_ACT_BIT] = active;
        reg_rdata[ST_ERR_BIT] = err_q;
        reg_rdata[ST_IRQ_BIT] = irq_q;
      end
      RA_TBL:  reg_rdata = 32'(tbl_q);
      default: reg_rdata = '0;
    endcase
  end

  assign start   = start_q;
  assign dir     = dir_q;
  assign tbl_ptr = tbl_q;
  assign err_st  = err_q;
  assign irq_st  = irq_q;
endmodule

// File: rtl/sgdma_seq.sv
module sgdma_seq
  import sgdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              stop,
  input  logic              dir,
  input  logic [ADDR_W-1:0] tbl_ptr,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              dev_req,
  output logic              active,
  output logic              err_set,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              dev_ack
);
  localparam int                CNT_W     = LEN_W + 1;
  localparam logic [CNT_W-1:0]  STEP_C    = CNT_W'(DATA_W / 8);
  localparam logic [ADDR_W-1:0] STEP_A    = ADDR_W'(DATA_W / 8);
  localparam logic [ADDR_W-1:0] HI_OFF    = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] DESC_SIZE = ADDR_W'(8);
  localparam logic [CNT_W-1:0]  FULL_LEN  = {1'b1, {LEN_W{1'b0}}};

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] fptr_q, fptr_d, base_q, base_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              eot_q, eot_d;
  logic [LEN_W-1:0]  desc_len;
  logic              beat_done, fetching;

  always_comb begin
    fetching  = (state_q == SEQ_DESC_LO) || (state_q == SEQ_DESC_HI);
    mem_req   = fetching || ((state_q == SEQ_MOVE) && dev_req);
    mem_we    = (state_q == SEQ_MOVE) && dir;
    mem_addr  = (state_q == SEQ_MOVE)    ? base_q :
                (state_q == SEQ_DESC_HI) ? fptr_q + HI_OFF : fptr_q;
    beat_done = (state_q == SEQ_MOVE) && dev_req && mem_ack;
    dev_ack   = beat_done;
    err_set   = mem_req && mem_err;
    active    = (state_q != SEQ_IDLE);
    desc_len  = mem_rdata[LEN_W-1:0];
  end

  always_comb begin
    state_d = state_q;
    fptr_d  = fptr_q;
    base_d  = base_q;
    cnt_d   = cnt_q;
    eot_d   = eot_q;
    if (stop || err_set) begin
      state_d = SEQ_IDLE;
    end else begin
      case (state_q)
        SEQ_IDLE: if (go) begin
          fptr_d  = tbl_ptr;
          state_d = SEQ_DESC_LO;
        end
        SEQ_DESC_LO: if (mem_ack) begin
          base_d  = {mem_rdata[ADDR_W-1:1], 1'b0};
          state_d = SEQ_DESC_HI;
        end
        SEQ_DESC_HI: if (mem_ack) begin
          cnt_d   = (desc_len == '0) ? FULL_LEN : {1'b0, desc_len};
          eot_d   = mem_rdata[DESC_EOT_BIT];
          fptr_d  = fptr_q + DESC_SIZE;
          state_d = SEQ_MOVE;
        end
        SEQ_MOVE: if (beat_done) begin
          base_d = base_q + STEP_A;
          if (cnt_q <= STEP_C) begin
            cnt_d   = '0;
            state_d = eot_q ? SEQ_IDLE : SEQ_DESC_LO;
          end else begin
            cnt_d = cnt_q - STEP_C;
          end
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      fptr_q  <= '0;
      base_q  <= '0;
      cnt_q   <= '0;
      eot_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      fptr_q  <= fptr_d;
      base_q  <= base_d;
      cnt_q   <= cnt_d;
      eot_q   <= eot_d;
    end
  end
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
  import sgdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic              dev_req,
  output logic              dev_ack,
  input  logic [DATA_W-1:0] dev_wdata,
  output logic [DATA_W-1:0] dev_rdata,
  input  logic              dev_irq
);
  logic              rst_meta, rst_sync;
  logic              start_w, dir_w, go_w, stop_w, err_w, irq_w, active_w, err_set_w;
  logic [ADDR_W-1:0] tbl_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  sgdma_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .active(active_w), .err_set(err_set_w), .dev_irq(dev_irq),
    .start(start_w), .dir(dir_w), .tbl_ptr(tbl_w), .go(go_w), .stop(stop_w),
    .err_st(err_w), .irq_st(irq_w)
  );

  sgdma_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_sync),
    .go(go_w), .stop(stop_w), .dir(dir_w), .tbl_ptr(tbl_w),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata), .dev_req(dev_req),
    .active(active_w), .err_set(err_set_w),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .dev_ack(dev_ack)
  );

  assign mem_wdata = dev_wdata;
  assign dev_rdata = mem_rdata;
endmodule

// File: rtl/sgdma_chk.sv
module sgdma_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       wr_start,
  input logic       mem_req,
  input logic       mem_ack,
  input logic       mem_err,
  input logic       dev_req,
  input logic       dev_ack,
  input logic       dev_irq,
  input logic       active,
  input logic       err_st,
  input logic       irq_st,
  input logic       start,
  input logic       dir
);
  // R9
  mem_err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_err) |=> (!active && err_st && !$rose(irq_st)));

  // R13
  dev_ack_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> (mem_ack && dev_req && active));

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && !wr_start) |=> (!active && !mem_req));

  // R2
  act_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(reg_wr && reg_addr == 2'd0 && wr_start));

  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_st) |-> $past(dev_irq));

  // R4
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> $stable(dir));
endmodule

bind sgdma_engine sgdma_chk u_chk (
  .clk(clk), .rst_n(rst_sync),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .wr_start(reg_wdata[0]),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_err(mem_err),
  .dev_req(dev_req), .dev_ack(dev_ack), .dev_irq(dev_irq),
  .active(active_w), .err_st(err_w), .irq_st(irq_w),
  .start(start_w), .dir(dir_w)
);

// File: tb/tb_sgdma_engine.sv
module tb_sgdma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic        dev_req = 1'b0, dev_ack;
  logic [31:0] dev_wdata = '0, dev_rdata;
  logic        dev_irq = 1'b0;

  int checks = 0, errors = 0;
  bit err_next = 0;
  bit finished = 0;

  typedef struct { logic [31:0] a; logic [31:0] d; bit we; } item_t;
  item_t       sbq[$];
  logic [31:0] memw[logic [31:0]];
  logic [31:0] seg_base[4];
  int          seg_words[4];
  int          nseg = 0;

  always #2 clk = ~clk;

  sgdma_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .dev_req(dev_req), .dev_ack(dev_ack), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
    .dev_irq(dev_irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return memw.exists(a) ? memw[a] : (a ^ 32'h5A5A_0000);
  endfunction

  // memory model: one-cycle answer, optional injected error
  initial begin
    forever begin
      @(posedge clk);
      if (mem_ack || mem_err) begin
        mem_ack <= 1'b0;
        mem_err <= 1'b0;
      end else if (mem_req) begin
        if (err_next) begin
          mem_err <= 1'b1;
          err_next = 0;
        end else begin
          mem_ack <= 1'b1;
          if (mem_we) memw[mem_addr] = mem_wdata;
          else mem_rdata <= rd(mem_addr);
        end
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && dev_ack) begin
      if (sbq.size() == 0) begin
        chk(0, "R13 unexpected beat", mem_addr, 32'hFFFF_FFFF);
      end else begin
        item_t it;
        it = sbq.pop_front();
        chk(mem_addr == it.a, "R12 beat address", mem_addr, it.a);
        chk(mem_we == it.we, "R4 beat direction", {31'b0, mem_we}, {31'b0, it.we});
        if (it.we) chk(mem_wdata == it.d, "R13 write data", mem_wdata, it.d);
        else       chk(dev_rdata == it.d, "R13 read data", dev_rdata, it.d);
      end
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [31:0] e, input string req);
    logic [31:0] v;
    rd_reg(a, v);
    chk(v == e, req, v, e);
  endtask

  task automatic add_desc(input int idx, input logic [31:0] ptr, input logic [31:0] base,
                          input logic [15:0] len, input bit eot);
    memw[ptr + 32'(8 * idx)]     = base;
    memw[ptr + 32'(8 * idx + 4)] = {eot, 15'b0, len};
    seg_base[idx]  = base;
    seg_words[idx] = (len == 16'd0) ? 16384 : int'(len) / 4;
    nseg = idx + 1;
  endtask

  function automatic logic [31:0] exp_addr(input int i);
    int k = i;
    for (int s = 0; s < nseg; s++) begin
      if (k < seg_words[s]) return seg_base[s] + 32'(4 * k);
      k -= seg_words[s];
    end
    return 32'hDEAD_0000;
  endfunction

  // device driver: pushes each expected beat, then waits for its acknowledge
  task automatic dev_xfer(input int first, input int n, input bit d2m, output int done);
    done = 0;
    for (int i = first; i < first + n; i++) begin
      item_t it;
      int w = 0;
      it.a  = exp_addr(i);
      it.we = d2m;
      it.d  = d2m ? (32'hD000_0000 + 32'(i) + {nseg[7:0], 24'h0}) : rd(it.a);
      dev_wdata = it.d;
      sbq.push_back(it);
      dev_req = 1'b1;
      @(negedge clk);
      while (!dev_ack && w < 50) begin
        w++;
        @(negedge clk);
      end
      if (!dev_ack) begin
        void'(sbq.pop_back());
        break;
      end
      @(posedge clk);
      #1 done++;
    end
    dev_req = 1'b0;
  endtask

  task automatic irq_pulse();
    @(negedge clk);
    dev_irq = 1'b1;
    repeat (2) @(negedge clk);
    dev_irq = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected done", checks);
    finish_run();
  end

  initial begin
    int done;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    expect_reg(2'd0, 32'h0, "R1 command after reset");
    expect_reg(2'd1, 32'h0, "R1 status after reset");
    expect_reg(2'd2, 32'h0, "R1 table pointer after reset");
    chk(!mem_req && !dev_ack, "R1 idle outputs", {30'b0, mem_req, dev_ack}, 32'h0);

    // normal completion, device to memory, split across two regions
    add_desc(0, 32'h100, 32'h1000, 16'd256, 1'b0);
    add_desc(1, 32'h100, 32'h2001, 16'd256, 1'b1);
    seg_base[1] = 32'h2000;  // R3 base bit 0 dropped
    wr_reg(2'd2, 32'h103);
    expect_reg(2'd2, 32'h100, "R1 table pointer low bits");
    wr_reg(2'd0, 32'h8);
    wr_reg(2'd0, 32'h9);
    chk(mem_req && !mem_we && mem_addr == 32'h100, "R2 first fetch", mem_addr, 32'h100);
    repeat (2) @(negedge clk);
    chk(mem_req && !mem_we && mem_addr == 32'h104, "R2 second fetch", mem_addr, 32'h104);
    dev_xfer(0, 10, 1'b1, done);
    expect_reg(2'd1, 32'h1, "R5 in progress");
    wr_reg(2'd1, 32'h1);
    expect_reg(2'd1, 32'h1, "R11 active read-only");
    dev_xfer(10, 118, 1'b1, done);
    chk(done == 118, "R3 second descriptor words", 32'(done), 32'd118);
    repeat (4) @(negedge clk);
    expect_reg(2'd1, 32'h0, "R6 table exhausted before interrupt");
    irq_pulse();
    expect_reg(2'd1, 32'h4, "R6 normal completion");
    wr_reg(2'd1, 32'h0);
    expect_reg(2'd1, 32'h4, "R11 write zero keeps interrupt");
    wr_reg(2'd1, 32'h4);
    expect_reg(2'd1, 32'h0, "R11 interrupt cleared");
    wr_reg(2'd0, 32'h8);

    // early completion, memory to device, direction lock, abort
    add_desc(0, 32'h200, 32'h3000, 16'd1024, 1'b1);
    wr_reg(2'd2, 32'h200);
    wr_reg(2'd0, 32'h0);
    expect_reg(2'd0, 32'h0, "R4 direction cleared while stopped");
    wr_reg(2'd0, 32'h1);
    wr_reg(2'd0, 32'h9);
    expect_reg(2'd0, 32'h1, "R4 direction locked while started");
    dev_xfer(0, 128, 1'b0, done);
    chk(done == 128, "R13 read beats", 32'(done), 32'd128);
    irq_pulse();
    expect_reg(2'd1, 32'h5, "R7 early completion");
    wr_reg(2'd1, 32'h4);
    wr_reg(2'd0, 32'h0);
    chk(!mem_req, "R10 requests end", {31'b0, mem_req}, 32'h0);
    expect_reg(2'd1, 32'h0, "R10 abort clears active");

    // zero count means a full 64 KiB region
    add_desc(0, 32'h300, 32'h8000, 16'd0, 1'b1);
    wr_reg(2'd2, 32'h300);
    wr_reg(2'd0, 32'h8);
    wr_reg(2'd0, 32'h9);
    dev_xfer(0, 130, 1'b1, done);
    chk(done == 130, "R3 zero count beats", 32'(done), 32'd130);
    expect_reg(2'd1, 32'h1, "R3 zero count still active");
    wr_reg(2'd0, 32'h8);

    // underflow: table smaller than device transfer
    add_desc(0, 32'h400, 32'h4000, 16'd256, 1'b1);
    wr_reg(2'd2, 32'h400);
    wr_reg(2'd0, 32'h9);
    dev_xfer(0, 128, 1'b1, done);
    chk(done == 64, "R8 beats before exhaustion", 32'(done), 32'd64);
    expect_reg(2'd1, 32'h0, "R8 underflow status");
    dev_req = 1'b1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      chk(!dev_ack && !mem_req, "R8 acknowledge withheld", {30'b0, dev_ack, mem_req}, 32'h0);
    end
    dev_req = 1'b0;
    wr_reg(2'd0, 32'h8);

    // memory error mid-transfer
    add_desc(0, 32'h500, 32'h5000, 16'd1024, 1'b1);
    wr_reg(2'd2, 32'h500);
    wr_reg(2'd0, 32'h9);
    dev_xfer(0, 20, 1'b1, done);
    err_next = 1;
    dev_xfer(20, 1, 1'b1, done);
    chk(done == 0, "R9 failed beat not acknowledged", 32'(done), 32'd0);
    expect_reg(2'd1, 32'h2, "R9 error status");
    irq_pulse();
    expect_reg(2'd1, 32'h2, "R9 no interrupt after error");
    wr_reg(2'd1, 32'h2);
    expect_reg(2'd1, 32'h0, "R11 error cleared");
    wr_reg(2'd0, 32'h8);

    // sector boundaries fall inside regions
    add_desc(0, 32'h600, 32'h6000, 16'd300, 1'b0);
    add_desc(1, 32'h600, 32'h7000, 16'd724, 1'b1);
    wr_reg(2'd2, 32'h600);
    wr_reg(2'd0, 32'h9);
    dev_xfer(0, 128, 1'b1, done);
    expect_reg(2'd1, 32'h1, "R12 mid-region sector end");
    dev_xfer(128, 128, 1'b1, done);
    chk(done == 128, "R12 second sector beats", 32'(done), 32'd128);
    repeat (4) @(negedge clk);
    irq_pulse();
    expect_reg(2'd1, 32'h4, "R12 completion after split");
    wr_reg(2'd1, 32'h4);
    wr_reg(2'd0, 32'h8);
    chk(sbq.size() == 0, "R13 all beats seen", 32'(sbq.size()), 32'd0);

    finish_run();
  end
endmodule